// File: doc/BRIEF.md
# Boot Sector Write Guard

This block sits between the command decoder of a sectored nonvolatile word memory and its embedded program/erase engine. For every program, sector-erase or chip-erase request it decides whether the operation may go ahead and, for erases, which of the four sectors the engine may clear. The word address is mapped onto a small boot sector, two parameter sectors and a large main sector. The `TOP_BOOT` parameter mirrors this map, so the boot sector can sit at either the lowest or the highest addresses.

A sticky lock flag, set by a lock command, shields the boot sector. While the flag is set, direct programs and erases of the boot sector are refused. A chip erase still runs but leaves the boot sector alone. A high-voltage override level on the reset pin, presented here as a logic input, lifts the shield for as long as it is held. The lock flag can be read back during identification reads.

Every write is also gated on the supply. Nothing is permitted while supply-good is low, or until a power-on delay has elapsed after it rises. The control pins must form a valid write strobe, and that strobe must have been stable for a minimum number of clocks, so short glitches cannot start an operation.

Top module: `bbp_guard`

## Requirements
- R1: With `TOP_BOOT=0` and 19 address bits, `sector_o` reports 0 (boot) for word addresses 00000h–01FFFh, 1 (parameter 1) for 02000h–02FFFh, 2 (parameter 2) for 03000h–03FFFh and 3 (main) for all higher addresses.
- R2: With `TOP_BOOT=1`, the map is mirrored: 0 for 7E000h–7FFFFh, 1 for 7D000h–7DFFFh, 2 for 7C000h–7CFFFh, and 3 for all lower addresses.
- R3: A cycle with `lock_cmd_i` high sets the lock flag from the next clock onward. The flag stays set until `rst_ni` is asserted, and it is clear after reset.
- R4: While locked, and without override, a program (`req_type_i`=00) or sector erase (01) aimed at sector 0 gets `permit_o`=0. The same requests aimed at sectors 1–3 are still permitted.
- R5: A qualified chip erase (10) is permitted. Its `erase_mask_o` is 1111b when unlocked or overridden and 1110b when locked. Mask bit i stands for sector i.
- R6: A permitted sector erase drives `erase_mask_o` one-hot at the bit of the target sector. A program, or any refused request, drives a zero mask.
- R7: While `override_i` is high, boot-sector programs and erases are permitted, and a chip erase mask includes bit 0, even when locked. Protection applies again in the first cycle in which `override_i` is low.
- R8: `id_lock_o` equals the lock flag when `id_mode_i` is high and the address is the boot sector base plus 2 (00002h bottom, 7E002h top). Otherwise it is 0.
- R9: `permit_o` is 0 while `supply_ok_i` is low. It also stays 0 until `supply_ok_i` has been sampled high on `POR_CYCLES` consecutive clock edges (default 16).
- R10: `permit_o` is 0 unless, in the request cycle, `ce_ni` is low, `we_ni` is low and `oe_ni` is high.
- R11: `permit_o` is 0 unless that strobe was also sampled on `GLITCH_CYCLES` consecutive edges (default 3) just before the request cycle.
- R12: The reserved request type 11 is never permitted and drives a zero mask.
- R13: During reset `permit_o`, `erase_mask_o` and `id_lock_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_type_i | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| addr_i | input | ADDR_W | Word address of the request or identification read |
| lock_cmd_i | input | 1 | Lock command, sets the sticky lock |
| override_i | input | 1 | High-voltage override level on the reset pin |
| supply_ok_i | input | 1 | Supply above the write threshold |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| id_mode_i | input | 1 | Identification read mode |
| sector_o | output | 2 | Decoded sector of `addr_i` |
| permit_o | output | 1 | Request may proceed |
| erase_mask_o | output | 4 | Sectors the erase may clear |
| id_lock_o | output | 1 | Lock status bit for identification reads |

## Verification
The assertions assume that `req_type_i` and `addr_i` are driven to known values whenever the block is out of reset. They also assume `override_i` is a level that is either held or released, never an edge, and they read request qualification only through the control pins and `supply_ok_i`. The stimulus changes every input just after a rising edge and keeps each level for at least one full cycle. It repeatedly breaks and re-forms the write strobe, so that the glitch and power-on windows are entered from every side. Both the bottom-boot and the top-boot build are driven with the same input stream.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
  typedef enum logic [1:0] {
    REQ_PROG       = 2'b00,
    REQ_SECT_ERASE = 2'b01,
    REQ_CHIP_ERASE = 2'b10,
    REQ_RSVD       = 2'b11
  } req_e;

  typedef enum logic [1:0] {
    SEC_BOOT = 2'd0,
    SEC_PAR1 = 2'd1,
    SEC_PAR2 = 2'd2,
    SEC_MAIN = 2'd3
  } sector_e;

  localparam int unsigned NUM_SECTORS = 4;
endpackage

// File: rtl/bbp_sector_decode.sv
module bbp_sector_decode
  import bbp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned BOOT_WORDS  = 8192,
  parameter int unsigned PARAM_WORDS = 4096,
  parameter int unsigned ID_OFFSET   = 2,
  parameter bit          TOP_BOOT    = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sector_e           sector_o,
  output logic              id_hit_o
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam logic [ADDR_W-1:0] LIM_BOOT = ADDR_W'(BOOT_WORDS);
  localparam logic [ADDR_W-1:0] LIM_PAR1 = ADDR_W'(BOOT_WORDS + PARAM_WORDS);
  localparam logic [ADDR_W-1:0] LIM_PAR2 = ADDR_W'(BOOT_WORDS + 2*PARAM_WORDS);

  // distance from the boot end of the array
  logic [ADDR_W-1:0] off;

  generate
    if (TOP_BOOT) begin : g_top
      localparam logic [ADDR_W-1:0] ID_OFF = ADDR_W'(BOOT_WORDS - 1 - ID_OFFSET);
      assign off      = ADDR_MAX - addr_i;
      assign id_hit_o = (off == ID_OFF);
    end else begin : g_bot
      localparam logic [ADDR_W-1:0] ID_OFF = ADDR_W'(ID_OFFSET);
      assign off      = addr_i;
      assign id_hit_o = (off == ID_OFF);
    end
  endgenerate

  always_comb begin
    if (off < LIM_BOOT)      sector_o = SEC_BOOT;
    else if (off < LIM_PAR1) sector_o = SEC_PAR1;
    else if (off < LIM_PAR2) sector_o = SEC_PAR2;
    else                     sector_o = SEC_MAIN;
  end
endmodule

// File: rtl/bbp_write_qual.sv
module bbp_write_qual #(
  parameter int unsigned POR_CYCLES    = 16,
  parameter int unsigned GLITCH_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic qual_o
);
  localparam int unsigned POR_W = $clog2(POR_CYCLES + 1);
  localparam logic [POR_W-1:0] POR_LIM = POR_W'(POR_CYCLES);

  logic [POR_W-1:0] por_q;
  logic             strobe;
  logic             wide;

  assign strobe = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              por_q <= '0;
    else if (!supply_ok_i)    por_q <= '0;
    else if (por_q != POR_LIM) por_q <= por_q + 1'b1;
  end

  generate
    if (GLITCH_CYCLES == 0) begin : g_nofilt
      assign wide = 1'b1;
    end else begin : g_filt
      localparam int unsigned GL_W = $clog2(GLITCH_CYCLES + 1);
      localparam logic [GL_W-1:0] GL_LIM = GL_W'(GLITCH_CYCLES);
      logic [GL_W-1:0] wid_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              wid_q <= '0;
        else if (!strobe)         wid_q <= '0;
        else if (wid_q != GL_LIM) wid_q <= wid_q + 1'b1;
      end
      assign wide = (wid_q == GL_LIM);
    end
  endgenerate

  assign qual_o = supply_ok_i & (por_q == POR_LIM) & strobe & wide;
endmodule

// File: rtl/bbp_lock_reg.sv
module bbp_lock_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lock_o <= 1'b0;
    else if (set_i) lock_o <= 1'b1;
  end
endmodule

// File: rtl/bbp_guard.sv
module bbp_guard
  import bbp_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned BOOT_WORDS    = 8192,
  parameter int unsigned PARAM_WORDS   = 4096,
  parameter int unsigned ID_OFFSET     = 2,
  parameter bit          TOP_BOOT      = 1'b0,
  parameter int unsigned POR_CYCLES    = 16,
  parameter int unsigned GLITCH_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lock_cmd_i,
  input  logic              override_i,
  input  logic              supply_ok_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              id_mode_i,
  output logic [1:0]        sector_o,
  output logic              permit_o,
  output logic [3:0]        erase_mask_o,
  output logic              id_lock_o
);
  sector_e sector;
  logic    id_hit;
  logic    qual;
  logic    lock_q;
  logic    boot_ok;
  req_e    rtype;

  bbp_sector_decode #(
    .ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS), .PARAM_WORDS(PARAM_WORDS),
    .ID_OFFSET(ID_OFFSET), .TOP_BOOT(TOP_BOOT)
  ) u_dec (
    .addr_i(addr_i), .sector_o(sector), .id_hit_o(id_hit)
  );

  bbp_write_qual #(
    .POR_CYCLES(POR_CYCLES), .GLITCH_CYCLES(GLITCH_CYCLES)
  ) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i),
    .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni), .qual_o(qual)
  );

  bbp_lock_reg u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(lock_cmd_i), .lock_o(lock_q)
  );

  assign rtype    = req_e'(req_type_i);
  assign boot_ok  = ~lock_q | override_i;
  assign sector_o = sector;
  assign id_lock_o = id_mode_i & id_hit & lock_q;

  always_comb begin
    permit_o     = 1'b0;
    erase_mask_o = '0;
    if (req_valid_i && qual) begin
      unique case (rtype)
        REQ_PROG: permit_o = (sector != SEC_BOOT) | boot_ok;
        REQ_SECT_ERASE: begin
          permit_o = (sector != SEC_BOOT) | boot_ok;
          for (int i = 0; i < NUM_SECTORS; i++)
            erase_mask_o[i] = permit_o & (sector == sector_e'(i));
        end
        REQ_CHIP_ERASE: begin
          permit_o     = 1'b1;
          erase_mask_o = {3'b111, boot_ok};  // locked boot silently skipped
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bbp_guard_sva.sv
module bbp_guard_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [1:0] req_type_i,
  input logic       lock_cmd_i,
  input logic       override_i,
  input logic       supply_ok_i,
  input logic       ce_ni,
  input logic       we_ni,
  input logic       oe_ni,
  input logic [1:0] sector_o,
  input logic       permit_o,
  input logic [3:0] erase_mask_o,
  input logic       lock_q
);
  a_r3_lock_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_cmd_i |=> lock_q);

  a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  a_r4_boot_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && lock_q && !override_i && sector_o == 2'd0 && req_type_i != 2'b10)
      |-> !permit_o);

  a_r5_chip_skips_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_type_i == 2'b10 && lock_q && !override_i) |-> !erase_mask_o[0]);

  a_r6_mask_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_type_i != 2'b10) |-> $onehot0(erase_mask_o));

  a_r9_no_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> !permit_o);

  a_r10_strobe_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_o |-> (!ce_ni && !we_ni && oe_ni));

  a_r11_strobe_before: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_o |-> $past(!ce_ni && !we_ni && oe_ni));

  a_r12_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_type_i == 2'b11) |-> (!permit_o && erase_mask_o == 4'b0));
endmodule

bind bbp_guard bbp_guard_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_type_i(req_type_i), .lock_cmd_i(lock_cmd_i), .override_i(override_i),
  .supply_ok_i(supply_ok_i), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
  .sector_o(sector_o), .permit_o(permit_o), .erase_mask_o(erase_mask_o),
  .lock_q(lock_q)
);

// File: tb/bbp_guard_test.sv
module bbp_guard_test;
  localparam int POR = 16;
  localparam int GL  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  rtype = 2'b00;
  logic [18:0] addr = '0;
  logic        lock_cmd = 1'b0;
  logic        ovr = 1'b0;
  logic        supply = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic        id_mode = 1'b0;

  logic [1:0] sec_b, sec_t;
  logic       perm_b, perm_t, idl_b, idl_t;
  logic [3:0] mask_b, mask_t;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R13";

  always #5 clk = ~clk;

  bbp_guard #(.TOP_BOOT(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_type_i(rtype),
    .addr_i(addr), .lock_cmd_i(lock_cmd), .override_i(ovr), .supply_ok_i(supply),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n), .id_mode_i(id_mode),
    .sector_o(sec_b), .permit_o(perm_b), .erase_mask_o(mask_b), .id_lock_o(idl_b));

  bbp_guard #(.TOP_BOOT(1'b1)) uut_top (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_type_i(rtype),
    .addr_i(addr), .lock_cmd_i(lock_cmd), .override_i(ovr), .supply_ok_i(supply),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n), .id_mode_i(id_mode),
    .sector_o(sec_t), .permit_o(perm_t), .erase_mask_o(mask_t), .id_lock_o(idl_t));

  // behavioural reference state
  int m_por = 0, m_wid = 0;
  bit m_lock = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_por = 0; m_wid = 0; m_lock = 0;
    end else begin
      if (lock_cmd) m_lock = 1;
      if (!supply) m_por = 0; else if (m_por < POR) m_por++;
      if (!ce_n && !we_n && oe_n) begin if (m_wid < GL) m_wid++; end
      else m_wid = 0;
    end
  end

  function automatic int sec_of(bit top, int a);
    if (!top) begin
      if (a <= 'h1FFF) return 0;
      if (a <= 'h2FFF) return 1;
      if (a <= 'h3FFF) return 2;
      return 3;
    end
    if (a >= 'h7E000) return 0;
    if (a >= 'h7D000) return 1;
    if (a >= 'h7C000) return 2;
    return 3;
  endfunction

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_one(bit top, int s_act, int p_act, int m_act, int i_act);
    int s, p, m, idx;
    bit go, boot_ok;
    s = sec_of(top, int'(addr));
    go = rst_n && valid && supply && m_por == POR && !ce_n && !we_n && oe_n && m_wid == GL;
    boot_ok = !m_lock || ovr;
    p = 0; m = 0;
    case (rtype)
      2'b00: p = go && (s != 0 || boot_ok);
      2'b01: begin p = go && (s != 0 || boot_ok); m = p ? (1 << s) : 0; end
      2'b10: begin p = go; m = p ? (boot_ok ? 'hF : 'hE) : 0; end
      default: begin p = 0; m = 0; end
    endcase
    idx = (rst_n && id_mode && m_lock && int'(addr) == (top ? 'h7E002 : 'h2)) ? 1 : 0;
    chk(top ? "top sector" : "bot sector", s_act, s);
    chk(top ? "top permit" : "bot permit", p_act, p);
    chk(top ? "top mask" : "bot mask", m_act, m);
    chk(top ? "top id_lock" : "bot id_lock", i_act, idx);
  endtask

  always @(negedge clk) begin
    check_one(1'b0, int'(sec_b), int'(perm_b), int'(mask_b), int'(idl_b));
    check_one(1'b1, int'(sec_t), int'(perm_t), int'(mask_t), int'(idl_t));
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe_on();
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
  endtask

  task automatic sweep(logic [1:0] t);
    int list [14] = '{'h0, 'h1FFF, 'h2000, 'h2FFF, 'h3000, 'h3FFF, 'h4000,
                      'h7BFFF, 'h7C000, 'h7CFFF, 'h7D000, 'h7DFFF, 'h7E000, 'h7FFFF};
    rtype = t; valid = 1'b1;
    foreach (list[i]) begin
      addr = 19'(list[i]);
      cyc(1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R13: reset state with a request pending
    cur_req = "R13"; strobe_on(); valid = 1'b1; id_mode = 1'b1; addr = 19'h2;
    cyc(3);
    rst_n = 1'b1; id_mode = 1'b0;
    // R9: no supply, then power-on delay
    cur_req = "R9"; addr = 19'h40000; cyc(5);
    supply = 1'b1; cyc(POR + 4);
    // R1, R2: decode and unlocked programs
    cur_req = "R1 R2"; sweep(2'b00);
    // R6: sector erase masks
    cur_req = "R6"; sweep(2'b01);
    // R5: chip erase unlocked
    cur_req = "R5"; rtype = 2'b10; cyc(2);
    // R8: identification reads before lock
    cur_req = "R8"; valid = 1'b0; id_mode = 1'b1;
    addr = 19'h2; cyc(1); addr = 19'h7E002; cyc(1); addr = 19'h3; cyc(1);
    // R3: lock command
    cur_req = "R3"; lock_cmd = 1'b1; cyc(1); lock_cmd = 1'b0; cyc(1);
    cur_req = "R8"; addr = 19'h2; cyc(1); addr = 19'h7E002; cyc(1);
    addr = 19'h7E003; cyc(1); id_mode = 1'b0;
    // R4: locked boot refused, others writable
    cur_req = "R4"; sweep(2'b00); sweep(2'b01);
    cur_req = "R5"; rtype = 2'b10; valid = 1'b1; cyc(2);
    // R7: override lifts and restores protection
    cur_req = "R7"; ovr = 1'b1; sweep(2'b01); rtype = 2'b10; cyc(1);
    ovr = 1'b0; cyc(1); rtype = 2'b00; addr = 19'h0; cyc(1);
    addr = 19'h7FFFF; ovr = 1'b1; cyc(1); ovr = 1'b0; cyc(1);
    // R10: control pins
    cur_req = "R10"; rtype = 2'b00; addr = 19'h40000;
    oe_n = 1'b0; cyc(2); strobe_on(); cyc(5);
    ce_n = 1'b1; cyc(2); strobe_on(); cyc(5);
    we_n = 1'b1; cyc(2); strobe_on(); cyc(5);
    // R11: glitch filter
    cur_req = "R11"; we_n = 1'b1; cyc(3);
    we_n = 1'b0; cyc(1); we_n = 1'b1; cyc(2);
    we_n = 1'b0; cyc(2); we_n = 1'b1; cyc(2);
    we_n = 1'b0; cyc(3); cyc(2);
    // R12: reserved type
    cur_req = "R12"; rtype = 2'b11; cyc(3);
    // R9: supply drop mid-stream
    cur_req = "R9"; rtype = 2'b01; supply = 1'b0; cyc(3);
    supply = 1'b1; cyc(POR - 1); cyc(3);
    // R3: reset clears lock
    cur_req = "R3"; rst_n = 1'b0; cyc(2); rst_n = 1'b1;
    cyc(POR + 2); addr = 19'h0; rtype = 2'b00; cyc(2);
    id_mode = 1'b1; addr = 19'h2; cyc(2);
    valid = 1'b0; id_mode = 1'b0; cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule